// File: doc/BRIEF.md
# Parallel Memory Strobe Decoder

This block sits behind the control, address and data pins of a byte-wide asynchronous memory port and turns the strobe activity into clean synchronous events for the logic behind it. All pins are sampled with a fast clock through multi-stage synchronisers. From the chip-select, output-enable and write-strobe levels the block classifies the bus as standby, idle, read or write. It drives a registered enable for the data-bus output buffers, and it emits a read request whenever a read begins or the read address moves.

Writes are framed by the overlap of chip-select and write-strobe. The address is taken at the moment the second of the two strobes goes active. The data is taken from the last sample before the first of the two strobes releases. A write-strobe pulse shorter than a parameterised number of clock cycles is discarded. A low output-enable or an asserted supply-low input at any point during the overlap voids the write. Each accepted overlap produces exactly one single-cycle write event that carries its address and data.

Top module: `strobe_decoder`

## Requirements
- R1: While chip-select and output-enable are both low, `bus_drive` is 1 and `bus_mode` reads 2 (read), whatever the write strobe does.
- R2: `bus_drive` is 0 whenever chip-select or output-enable is high.
- R3: `bus_mode` is 0 (standby) whenever chip-select is high. With chip-select low and output-enable high it is 3 (write) while the filtered write strobe is low, and 1 (idle) otherwise.
- R4: An overlap of low chip-select and low write strobe, with output-enable high throughout, produces exactly one single-cycle `wr_valid` pulse after the overlap ends.
- R5: The write address is the one present when the later of the two strobes fell. Address changes after that point, including changes inside the glitch-filter window, are not taken.
- R6: The write data is the value on the data pins in the last sample before the earlier of the two strobes rose. A change that lands together with that rise is not taken.
- R7: A write-strobe low pulse of fewer than `GLITCH_CYC` clock cycles produces no write event. A pulse of exactly `GLITCH_CYC` cycles does produce one.
- R8: If output-enable is low at any point during a strobe overlap, that overlap produces no write event.
- R9: While `supply_low` is 1, no write event is produced. A write event therefore never follows `supply_low` being high two cycles earlier.
- R10: `rd_req` pulses for one cycle with `rd_addr` when a read begins, and again each time the address changes while the read is held.
- R11: During and just after reset, `bus_drive`, `rd_req` and `wr_valid` are 0 and `bus_mode` is 0. Pin synchronisers reset to the inactive (high) strobe level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n_pin | input | 1 | Chip-select pin, active low, asynchronous |
| oe_n_pin | input | 1 | Output-enable pin, active low, asynchronous |
| we_n_pin | input | 1 | Write-strobe pin, active low, asynchronous |
| addr_pin | input | AW | Address pins |
| data_pin | input | DW | Data pins (input side of the bus) |
| supply_low | input | 1 | Synchronous supply-low indication; blocks writes |
| bus_mode | output | 2 | 0 standby, 1 idle, 2 read, 3 write |
| bus_drive | output | 1 | Enable for the data-bus output buffers |
| rd_req | output | 1 | Single-cycle read request |
| rd_addr | output | AW | Address of the read request |
| wr_valid | output | 1 | Single-cycle write event |
| wr_addr | output | AW | Address of the write event |
| wr_data | output | DW | Data of the write event |

## Verification
The bench walks every combination of the three strobes and checks the decoded mode and bus enable. A swapped priority would let a write show through during a read, or let the bus drive in standby. It then goes after the capture edges. In a chip-select-controlled write the address moves just before chip-select falls and the data moves on the very cycle chip-select rises. In a write-strobe-controlled write the address moves inside the glitch-filter window. A design that latched on the wrong edge, or one cycle late, reports the neighbouring value. Write pulses one cycle under and exactly at the filter length expose an off-by-one in the filter. Overlaps broken by output-enable or by supply-low expose a missing inhibit as a spurious write event. Read address changes during a held read check that every new address is requested.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_IDLE    = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } bus_mode_e;

  typedef enum logic [1:0] {
    WC_IDLE    = 2'd0,
    WC_ACTIVE  = 2'd1,
    WC_BLOCKED = 2'd2
  } wcap_state_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/we_glitch_filter.sv
module we_glitch_filter #(
  parameter int GLITCH_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic we_n_in,
  output logic we_n_out
);

  localparam int CW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC) : 1;

  generate
    if (GLITCH_CYC <= 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) we_n_out <= 1'b1;
        else     we_n_out <= we_n_in;
      end
    end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);
      logic [CW-1:0] cnt;
      // Release is immediate; assertion needs GLITCH_CYC consecutive low samples.
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt      <= '0;
          we_n_out <= 1'b1;
        end else if (we_n_in) begin
          cnt      <= '0;
          we_n_out <= 1'b1;
        end else if (cnt == LAST) begin
          we_n_out <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/write_capture.sv
module write_capture
  import strobe_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n_raw,
  input  logic          we_n_f,
  input  logic          oe_n,
  input  logic          sup_low,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_prev,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  wcap_state_e   state;
  logic          raw_act, raw_act_q;
  logic [AW-1:0] addr_cand, addr_start, addr_q;
  logic          strobe, inhibit;

  assign raw_act    = !ce_n && !we_n_raw;
  assign strobe     = !ce_n && !we_n_f;
  assign inhibit    = !oe_n || sup_low;
  // Address at the moment the later strobe fell, before filtering delays it.
  assign addr_start = (raw_act && !raw_act_q) ? addr : addr_cand;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_act_q <= 1'b0;
      addr_cand <= '0;
    end else begin
      raw_act_q <= raw_act;
      if (raw_act && !raw_act_q) addr_cand <= addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= WC_IDLE;
      addr_q   <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      unique case (state)
        WC_IDLE: begin
          if (strobe) begin
            if (inhibit) begin
              state <= WC_BLOCKED;
            end else begin
              state  <= WC_ACTIVE;
              addr_q <= addr_start;
            end
          end
        end
        WC_ACTIVE: begin
          if (inhibit) begin
            state <= WC_BLOCKED;
          end else if (!strobe) begin
            state    <= WC_IDLE;
            wr_valid <= 1'b1;
            wr_addr  <= addr_q;
            wr_data  <= data_prev;
          end
        end
        WC_BLOCKED: begin
          if (!strobe) state <= WC_IDLE;
        end
        default: state <= WC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import strobe_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n_f,
  input  logic [AW-1:0] addr,
  output bus_mode_e     mode,
  output logic          bus_oe,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr
);

  logic      rd_act, rd_act_q;
  bus_mode_e mode_d;

  assign rd_act = !ce_n && !oe_n;

  always_comb begin
    if (ce_n)        mode_d = MODE_STANDBY;
    else if (!oe_n)  mode_d = MODE_READ;
    else if (!we_n_f) mode_d = MODE_WRITE;
    else             mode_d = MODE_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_STANDBY;
      bus_oe   <= 1'b0;
      rd_act_q <= 1'b0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
    end else begin
      mode     <= mode_d;
      bus_oe   <= rd_act;
      rd_act_q <= rd_act;
      rd_req   <= 1'b0;
      if (rd_act && (!rd_act_q || addr != rd_addr)) begin
        rd_req  <= 1'b1;
        rd_addr <= addr;
      end
    end
  end

endmodule

// File: rtl/strobe_decoder.sv
module strobe_decoder
  import strobe_pkg::*;
#(
  parameter int AW          = 13,
  parameter int DW          = 8,
  parameter int GLITCH_CYC  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n_pin,
  input  logic          oe_n_pin,
  input  logic          we_n_pin,
  input  logic [AW-1:0] addr_pin,
  input  logic [DW-1:0] data_pin,
  input  logic          supply_low,
  output logic [1:0]    bus_mode,
  output logic          bus_drive,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  localparam int BUS_W = AW + DW;

  logic [2:0]       ctl_s;
  logic [BUS_W-1:0] bus_s;
  logic             we_f;
  logic             ce_a, oe_a, we_a, sup_a;
  logic [AW-1:0]    addr_a;
  logic [DW-1:0]    data_a, data_b;
  bus_mode_e        mode_q;

  pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
    .clk(clk), .rst(rst),
    .d({ce_n_pin, oe_n_pin, we_n_pin}),
    .q(ctl_s)
  );

  pin_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst(rst),
    .d({addr_pin, data_pin}),
    .q(bus_s)
  );

  we_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk(clk), .rst(rst),
    .we_n_in(ctl_s[0]),
    .we_n_out(we_f)
  );

  // Align stage: matches the one-register release latency of the filter.
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_a   <= 1'b1;
      oe_a   <= 1'b1;
      we_a   <= 1'b1;
      sup_a  <= 1'b0;
      addr_a <= '0;
      data_a <= '0;
      data_b <= '0;
    end else begin
      ce_a   <= ctl_s[2];
      oe_a   <= ctl_s[1];
      we_a   <= ctl_s[0];
      sup_a  <= supply_low;
      addr_a <= bus_s[BUS_W-1:DW];
      data_a <= bus_s[DW-1:0];
      data_b <= data_a;
    end
  end

  mode_decode #(.AW(AW)) u_mode (
    .clk(clk), .rst(rst),
    .ce_n(ce_a), .oe_n(oe_a), .we_n_f(we_f),
    .addr(addr_a),
    .mode(mode_q),
    .bus_oe(bus_drive),
    .rd_req(rd_req),
    .rd_addr(rd_addr)
  );

  write_capture #(.AW(AW), .DW(DW)) u_wcap (
    .clk(clk), .rst(rst),
    .ce_n(ce_a), .we_n_raw(we_a), .we_n_f(we_f),
    .oe_n(oe_a), .sup_low(sup_a),
    .addr(addr_a), .data_prev(data_b),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign bus_mode = mode_q;

endmodule

// File: rtl/strobe_decoder_chk.sv
module strobe_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] bus_mode,
  input logic       bus_drive,
  input logic       rd_req,
  input logic       wr_valid,
  input logic       supply_low
);

  assert_drive_means_read_R1: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> (bus_mode == 2'd2));

  assert_standby_no_drive_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_mode == 2'd0) |-> !bus_drive);

  assert_single_event_R4: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  assert_no_write_in_read_R8: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !bus_drive);

  assert_supply_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !$past(supply_low, 2));

  assert_req_while_driving_R10: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> bus_drive);

endmodule

bind strobe_decoder strobe_decoder_chk u_chk (
  .clk(clk),
  .rst(rst),
  .bus_mode(bus_mode),
  .bus_drive(bus_drive),
  .rd_req(rd_req),
  .wr_valid(wr_valid),
  .supply_low(supply_low)
);

// File: tb/sim_strobe_decoder.sv
module sim_strobe_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int GLITCH = 4;

  // {ce_n, oe_n, we_n, expected bus_drive, expected mode[1:0]}
  localparam logic [5:0] VEC [8] = '{
    6'b111_0_00, 6'b101_0_00, 6'b100_0_00, 6'b011_0_01,
    6'b001_1_10, 6'b010_0_11, 6'b000_1_10, 6'b110_0_00
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, supply_low = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [1:0] bus_mode;
  logic bus_drive, rd_req, wr_valid;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [AW-1:0] last_wa = '0, last_ra = '0;
  logic [DW-1:0] last_wd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_decoder #(.AW(AW), .DW(DW), .GLITCH_CYC(GLITCH), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst),
    .ce_n_pin(ce_n), .oe_n_pin(oe_n), .we_n_pin(we_n),
    .addr_pin(addr), .data_pin(data), .supply_low(supply_low),
    .bus_mode(bus_mode), .bus_drive(bus_drive),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      wr_cnt  <= wr_cnt + 1;
      last_wa <= wr_addr;
      last_wd <= wr_data;
    end
    if (!rst && rd_req) begin
      rd_cnt  <= rd_cnt + 1;
      last_ra <= rd_addr;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_pins();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic we_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
    @(negedge clk);
    addr = a; data = d; oe_n = 1'b1; ce_n = 1'b0;
    cyc(2);
    we_n = 1'b0;
    cyc(len);
    we_n = 1'b1; data = ~d;
    cyc(3);
    ce_n = 1'b1;
    cyc(10);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int wr0, rd0;
    // R11: reset state
    cyc(5);
    chk("R11 drive in reset", 32'(bus_drive), 32'd0);
    chk("R11 wr_valid in reset", 32'(wr_valid), 32'd0);
    chk("R11 rd_req in reset", 32'(rd_req), 32'd0);
    rst = 1'b0;
    cyc(3);
    chk("R11 mode after reset", 32'(bus_mode), 32'd0);
    chk("R11 drive after reset", 32'(bus_drive), 32'd0);

    // Vector walk: R1 R2 R3
    wr0 = wr_cnt;
    for (int i = 0; i < 8; i++) begin
      ce_n = VEC[i][5]; oe_n = VEC[i][4]; we_n = VEC[i][3];
      cyc(10);
      chk($sformatf("R1/R2 drive vec %0d", i), 32'(bus_drive), 32'(VEC[i][2]));
      chk($sformatf("R3 mode vec %0d", i), 32'(bus_mode), 32'(VEC[i][1:0]));
    end
    idle_pins();
    cyc(10);
    chk("R8 no event from read-broken strobe", 32'(wr_cnt - wr0), 32'd0);

    // R4 R6: write-strobe controlled write
    wr0 = wr_cnt;
    we_write(13'h0155, 8'h3C, 6);
    chk("R4 one event", 32'(wr_cnt - wr0), 32'd1);
    chk("R4 address", 32'(last_wa), 32'h0155);
    chk("R6 data before strobe rise", 32'(last_wd), 32'h3C);

    // R7: glitch boundary
    wr0 = wr_cnt;
    we_write(13'h0AAA, 8'h11, GLITCH - 1);
    chk("R7 short pulse ignored", 32'(wr_cnt - wr0), 32'd0);
    we_write(13'h0AAB, 8'h22, GLITCH);
    chk("R7 full pulse taken", 32'(wr_cnt - wr0), 32'd1);
    chk("R7 full pulse data", 32'(last_wd), 32'h22);

    // R5 R6: chip-select controlled, chip-select falls last and rises first
    wr0 = wr_cnt;
    oe_n = 1'b1; addr = 13'h0101; data = 8'hA5; we_n = 1'b0;
    cyc(6);
    addr = 13'h0202; ce_n = 1'b0;
    cyc(3);
    addr = 13'h0303;
    cyc(3);
    ce_n = 1'b1; data = 8'h5A;
    cyc(3);
    we_n = 1'b1;
    cyc(10);
    chk("R4 ce-controlled one event", 32'(wr_cnt - wr0), 32'd1);
    chk("R5 address at later fall (ce)", 32'(last_wa), 32'h0202);
    chk("R6 data before earlier rise (ce)", 32'(last_wd), 32'hA5);

    // R5: write strobe falls last, address moves inside filter window
    wr0 = wr_cnt;
    addr = 13'h0404; data = 8'h77; ce_n = 1'b0;
    cyc(4);
    addr = 13'h0505; we_n = 1'b0;
    cyc(2);
    addr = 13'h0606;
    cyc(4);
    we_n = 1'b1;
    cyc(3);
    ce_n = 1'b1;
    cyc(10);
    chk("R5 event count (we last)", 32'(wr_cnt - wr0), 32'd1);
    chk("R5 address at later fall (we)", 32'(last_wa), 32'h0505);

    // R8: output-enable pulse inside an overlap
    wr0 = wr_cnt;
    addr = 13'h0707; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    cyc(7);
    oe_n = 1'b0;
    cyc(2);
    oe_n = 1'b1;
    cyc(3);
    we_n = 1'b1;
    cyc(2);
    ce_n = 1'b1;
    cyc(10);
    chk("R8 oe low voids write", 32'(wr_cnt - wr0), 32'd0);

    // R9: supply-low blocks, then release allows
    wr0 = wr_cnt;
    supply_low = 1'b1;
    we_write(13'h0808, 8'h99, 6);
    chk("R9 blocked by supply_low", 32'(wr_cnt - wr0), 32'd0);
    supply_low = 1'b0;
    cyc(3);
    we_write(13'h0809, 8'h98, 6);
    chk("R9 allowed after supply ok", 32'(wr_cnt - wr0), 32'd1);
    chk("R9 address after supply ok", 32'(last_wa), 32'h0809);

    // R10: read requests on start and on address change
    rd0 = rd_cnt;
    addr = 13'h0123; ce_n = 1'b0; oe_n = 1'b0;
    cyc(8);
    chk("R10 request at read start", 32'(rd_cnt - rd0), 32'd1);
    chk("R10 start address", 32'(last_ra), 32'h0123);
    addr = 13'h1FFF;
    cyc(8);
    chk("R10 request on address change", 32'(rd_cnt - rd0), 32'd2);
    chk("R10 new address", 32'(last_ra), 32'h1FFF);
    cyc(8);
    chk("R10 no request on steady address", 32'(rd_cnt - rd0), 32'd2);
    oe_n = 1'b1;
    cyc(8);
    chk("R2 drive off after oe rise", 32'(bus_drive), 32'd0);
    ce_n = 1'b1;
    cyc(8);
    chk("R3 standby after ce rise", 32'(bus_mode), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule